// File: doc/BRIEF.md
# Dual-Threshold Time-Over-Threshold Hit Recorder

This block turns the digital outputs of per-channel discriminator pairs into timed hit records. Each channel has a low (read) comparator and a high (confirmation) comparator. The low comparator's asserted interval opens a window. A pulse is kept only if the high comparator is seen asserted at a sample inside that window. For a kept pulse, the block writes two records into that channel's FIFO: the time at which the low comparator rose, and the time at which it fell. Pulse height is carried by the width between the two records, so no analog conversion and no trigger-latency buffering are needed. A later stage turns that width into charge.

The block runs on one fast clock. A phase counter divides it into sample periods of `SLOTS` cycles. On the last cycle of each period the comparators are sampled and the event-time counter advances. Channels are grouped in banks of `SLOTS`. In each fast cycle one channel owns the shared output: the slot phase picks the channel inside a bank, and the banks take turns from one sample period to the next. If the owning channel has a stored record, that record goes out; otherwise the output carries an all-zero idle word. Each FIFO keeps back room for the trailing record before it accepts a leading one, so a pair is never split. A pulse that finds too little room is dropped whole, and a sticky overflow flag is raised. `NCH` and `SLOTS` are powers of two, with `NCH` a multiple of `SLOTS`.

Top module: `tot_hit_recorder`

## Requirements
- R1: A sample tick occurs on every `SLOTS`-th rising clock edge, the first being edge number `SLOTS-1` counted from 0 after reset release. The event time starts at 0, rises by one at each tick and wraps modulo 2^`TS_W`. The time stamped on an edge is the count of ticks before the tick that observed it.
- R2: Each comparator input passes through a two-flop synchronizer and is looked at only on ticks. A level that is applied right after one tick and held is observed at the following tick.
- R3: A pulse is accepted only if the high comparator is sampled high at a tick where the low comparator is also sampled high. This includes the tick at which the low comparator first reads high. The leading record carries the time of that first high low-sample.
- R4: For an accepted pulse, the trailing record carries the time of the first tick at which the low comparator reads low again. It is written after the leading record of the same channel. Records of one channel leave the block in the order they were written.
- R5: A low window that closes with no high-comparator sample inside it writes nothing.
- R6: High-comparator activity while the low comparator reads low writes nothing. This includes a high assertion that arrives at the tick the window closes, or later.
- R7: Output word fields: `out_valid`=1 marks a record. `out_chan` is the channel index. `out_trail` is 0 for a leading record and 1 for a trailing record. `out_time` is the record's event time. The channel served at edge k is bank (k/`SLOTS`) mod (`NCH`/`SLOTS`), slot k mod `SLOTS`, and its word appears at the outputs right after edge k. An idle word has every field at 0.
- R8: A leading record is written only if its channel FIFO has at least two free entries. Otherwise the whole pulse is dropped: neither record is written, and `overflow` goes to 1 and stays there until reset.
- R9: During and right after reset, `out_valid`, `out_chan`, `out_trail`, `out_time` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one output slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_low | input | NCH | Low-threshold comparator outputs, one bit per channel |
| cmp_high | input | NCH | High-threshold comparator outputs, one bit per channel |
| out_valid | output | 1 | Current output word holds a record |
| out_chan | output | $clog2(NCH) | Channel index of the record |
| out_trail | output | 1 | 0 = leading edge, 1 = trailing edge |
| out_time | output | TS_W | Event time of the edge |
| overflow | output | 1 | Sticky: a pulse was dropped for lack of FIFO room |

## Verification
The assertions assume that reset is held for at least one clock and that the comparator inputs are plain levels. The pairing checks further assume that each synchronized comparator changes at most once per sample period, so that a rise and a fall never fall inside the same period. The stimulus changes comparator levels only on the falling clock edge right after a tick, and holds them for whole sample periods, so every level is settled through the synchronizer long before the next tick. Overflow is forced by giving one channel pulses one tick long, back to back, so that writes come twice as fast as that channel's share of output slots can drain them.

// File: rtl/tot_pkg.sv
package tot_pkg;

  // Record kind carried in the top bit of every FIFO word.
  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } edge_e;

  // True when a FIFO holding `used` entries can still take a full pair.
  function automatic logic pair_fits(int unsigned used, int unsigned depth);
    return (used + 2) <= depth;
  endfunction

  // Event time after one tick, wrapping at the counter width.
  function automatic logic [31:0] time_next(logic [31:0] t, int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (t + 32'd1) & mask;
  endfunction

endpackage

// File: rtl/tot_sync.sv
module tot_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/tot_chan.sv
module tot_chan #(
  parameter int TS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            low_s,
  input  logic            high_s,
  input  logic [TS_W-1:0] now,
  input  logic            room_ok,
  output logic            wr_lead,
  output logic            wr_trail,
  output logic [TS_W-1:0] wr_time,
  output logic            drop
);
  logic            low_q;    // low comparator at previous tick
  logic            pend_q;   // window open, not yet confirmed
  logic            open_q;   // leading record written, trailing owed
  logic [TS_W-1:0] lead_t_q;

  logic rise, fall, confirm;

  assign rise    = tick &  low_s & ~low_q;
  assign fall    = tick & ~low_s &  low_q;
  assign confirm = tick &  low_s & high_s & (rise | pend_q);

  assign wr_lead  = confirm & room_ok;
  assign drop     = confirm & ~room_ok;
  assign wr_trail = fall & open_q;
  assign wr_time  = (rise | fall) ? now : lead_t_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q    <= 1'b0;
      pend_q   <= 1'b0;
      open_q   <= 1'b0;
      lead_t_q <= '0;
    end else begin
      if (tick) low_q <= low_s;
      if (rise) lead_t_q <= now;
      if (confirm || fall) pend_q <= 1'b0;
      else if (rise)       pend_q <= 1'b1;
      if (wr_lead)   open_q <= 1'b1;
      else if (fall) open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tot_fifo.sv
module tot_fifo #(
  parameter int DW    = 13,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] used
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign used    = cnt_q;
  assign dout    = mem[rp_q];
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_inc(wp_q);
      if (do_pop)  rp_q <= ptr_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tot_hit_recorder.sv
module tot_hit_recorder #(
  parameter int NCH   = 16,
  parameter int SLOTS = 8,
  parameter int TS_W  = 12,
  parameter int DEPTH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  cmp_low,
  input  logic [NCH-1:0]  cmp_high,
  output logic            out_valid,
  output logic [CH_W-1:0] out_chan,
  output logic            out_trail,
  output logic [TS_W-1:0] out_time,
  output logic            overflow
);
  import tot_pkg::*;

  localparam int GROUPS = NCH / SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int DW     = TS_W + 1;
  localparam int CW     = $clog2(DEPTH + 1);

  // Named internal events, brought out for the bound checker.
  logic              tick;
  logic [TS_W-1:0]   ts_q;
  logic [SLOT_W-1:0] ph_q;
  logic [CH_W-1:0]   served;
  logic [NCH-1:0]    low_s, high_s;
  logic [NCH-1:0]    wr_lead_v, wr_trail_v, drop_v, push_v, pop_v;
  logic [NCH-1:0]    empty_v, full_v, room_ok;
  logic [TS_W-1:0]   wr_time_a [NCH];
  logic [DW-1:0]     head_a    [NCH];
  logic [CW-1:0]     used_a    [NCH];
  logic              ovf_q;

  // Slot phase and sample tick.
  assign tick = (ph_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
      ts_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (tick) ts_q <= TS_W'(time_next(32'(ts_q), TS_W));
    end
  end

  // Bank rotation across sample periods.
  generate
    if (GROUPS > 1) begin : g_banks
      logic [GRP_W-1:0] grp_q;
      always_ff @(posedge clk) begin
        if (!rst_n)    grp_q <= '0;
        else if (tick) grp_q <= grp_q + 1'b1;
      end
      assign served = {grp_q, ph_q};
    end else begin : g_single
      assign served = CH_W'(ph_q);
    end
  endgenerate

  tot_sync #(.W(NCH)) u_sync_low  (.clk(clk), .rst_n(rst_n), .d(cmp_low),  .q(low_s));
  tot_sync #(.W(NCH)) u_sync_high (.clk(clk), .rst_n(rst_n), .d(cmp_high), .q(high_s));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      tot_chan #(.TS_W(TS_W)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .low_s    (low_s[c]),
        .high_s   (high_s[c]),
        .now      (ts_q),
        .room_ok  (room_ok[c]),
        .wr_lead  (wr_lead_v[c]),
        .wr_trail (wr_trail_v[c]),
        .wr_time  (wr_time_a[c]),
        .drop     (drop_v[c])
      );

      assign push_v[c]  = wr_lead_v[c] | wr_trail_v[c];
      assign pop_v[c]   = (served == CH_W'(c)) && !empty_v[c];
      assign room_ok[c] = pair_fits(32'(used_a[c]), DEPTH);

      tot_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_v[c]),
        .din   ({wr_trail_v[c], wr_time_a[c]}),
        .pop   (pop_v[c]),
        .dout  (head_a[c]),
        .empty (empty_v[c]),
        .full  (full_v[c]),
        .used  (used_a[c])
      );
    end
  endgenerate

  // Shared output word, one slot per cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_trail <= 1'b0;
      out_time  <= '0;
    end else if (!empty_v[served]) begin
      out_valid <= 1'b1;
      out_chan  <= served;
      out_trail <= head_a[served][TS_W];
      out_time  <= head_a[served][TS_W-1:0];
    end else begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_trail <= 1'b0;
      out_time  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_q | (|drop_v);
  end
  assign overflow = ovf_q;

endmodule

// File: rtl/tot_chk.sv
module tot_chk #(
  parameter int NCH  = 16,
  parameter int TS_W = 12,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [TS_W-1:0] ts,
  input logic [NCH-1:0]  wr_lead,
  input logic [NCH-1:0]  wr_trail,
  input logic [NCH-1:0]  fifo_full,
  input logic [NCH-1:0]  drop,
  input logic            out_valid,
  input logic [CH_W-1:0] out_chan,
  input logic            out_trail,
  input logic [TS_W-1:0] out_time,
  input logic            overflow
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ts == TS_W'($past(ts) + 1'b1)); // R1
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ts)); // R1
  AST_WRITE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wr_lead | wr_trail)) |-> tick); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_chan == '0 && !out_trail && out_time == '0)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop) |=> overflow); // R8

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_pair
      logic open_q;
      always_ff @(posedge clk) begin
        if (!rst_n)           open_q <= 1'b0;
        else if (wr_lead[c])  open_q <= 1'b1;
        else if (wr_trail[c]) open_q <= 1'b0;
      end
      AST_LEAD_WHEN_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lead[c] |-> !open_q); // R4
      AST_TRAIL_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_trail[c] |-> open_q); // R4
      AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full[c] |-> !(wr_lead[c] | wr_trail[c])); // R8
      AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lead[c] && drop[c])); // R8
    end
  endgenerate
endmodule

bind tot_hit_recorder tot_chk #(.NCH(NCH), .TS_W(TS_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .ts        (ts_q),
  .wr_lead   (wr_lead_v),
  .wr_trail  (wr_trail_v),
  .fifo_full (full_v),
  .drop      (drop_v),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .out_trail (out_trail),
  .out_time  (out_time),
  .overflow  (overflow)
);

// File: tb/test_tot_hit_recorder.sv
`timescale 1ns/1ps
module test_tot_hit_recorder;
  localparam int NCH = 16, SLOTS = 8, TS_W = 12, DEPTH = 4;
  localparam int TMOD = 1 << TS_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  lo = '0, hi = '0;
  logic            out_valid, out_trail, overflow;
  logic [3:0]      out_chan;
  logic [TS_W-1:0] out_time;

  int nchk = 0, nerr = 0;
  int bcyc = 0;
  int nrec = 0;
  int slot_bad = 0;
  int slot_seen = 0;
  int rch [0:511];
  int rtr [0:511];
  int rtm [0:511];
  bit done = 1'b0;

  always #4 clk = ~clk;

  tot_hit_recorder #(.NCH(NCH), .SLOTS(SLOTS), .TS_W(TS_W), .DEPTH(DEPTH)) i_tot_hit_recorder (
    .clk(clk), .rst_n(rst_n), .cmp_low(lo), .cmp_high(hi),
    .out_valid(out_valid), .out_chan(out_chan), .out_trail(out_trail),
    .out_time(out_time), .overflow(overflow)
  );

  always @(posedge clk) begin
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;
  end

  // Record capture and slot-ownership check (R7), away from the edge.
  always @(negedge clk) begin
    if (rst_n && bcyc > 0 && out_valid) begin
      int k, expc;
      k = bcyc - 1;
      expc = ((k / SLOTS) % (NCH / SLOTS)) * SLOTS + (k % SLOTS);
      slot_seen++;
      if (int'(out_chan) != expc) slot_bad++;
      if (nrec < 512) begin
        rch[nrec] = int'(out_chan);
        rtr[nrec] = int'(out_trail);
        rtm[nrec] = int'(out_time);
        nrec++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Park on the falling edge right after a tick.
  task automatic to_tick();
    do @(negedge clk); while (bcyc % SLOTS != 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) to_tick();
  endtask

  // Stamp given to a level applied now (R1, R2).
  function automatic int stamp();
    return (bcyc / SLOTS) % TMOD;
  endfunction

  function automatic int count_ch(input int c, input int base);
    int n = 0;
    for (int i = base; i < nrec; i++) if (rch[i] == c) n++;
    return n;
  endfunction

  function automatic int nth_ch(input int c, input int nth, input int base);
    int n = 0;
    for (int i = base; i < nrec; i++) begin
      if (rch[i] == c) begin
        if (n == nth) return i;
        n++;
      end
    end
    return -1;
  endfunction

  task automatic expect_pair(input string tag, input int c, input int base,
                             input int t_lead, input int t_trail);
    int a, b;
    chk(count_ch(c, base) == 2, {tag, " record count"}, count_ch(c, base), 2);
    a = nth_ch(c, 0, base);
    b = nth_ch(c, 1, base);
    if (a >= 0 && b >= 0) begin
      chk(rtr[a] == 0 && rtm[a] == t_lead, {tag, " leading time"}, rtm[a], t_lead);
      chk(rtr[b] == 1 && rtm[b] == t_trail, {tag, " trailing time"}, rtm[b], t_trail);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid && out_chan == 0 && !out_trail && out_time == 0,
        "R9 output idle after reset", int'(out_valid), 0);
    chk(!overflow, "R9 overflow clear after reset", int'(overflow), 0);
  endtask

  task automatic t_accept();
    int base, a, b;
    to_tick();
    base = nrec;
    a = stamp(); lo[2] = 1'b1;
    ticks(2); hi[2] = 1'b1;
    ticks(1); hi[2] = 1'b0;
    ticks(2); b = stamp(); lo[2] = 1'b0;
    ticks(6);
    expect_pair("R3 R4 late confirm ch2", 2, base, a, b);
    chk(b - a == 5, "R2 width in ticks", b - a, 5);
  endtask

  task automatic t_same_tick();
    int base, a, b;
    to_tick();
    base = nrec;
    a = stamp(); lo[13] = 1'b1; hi[13] = 1'b1;
    ticks(3); b = stamp(); lo[13] = 1'b0; hi[13] = 1'b0;
    ticks(6);
    expect_pair("R3 confirm on rising tick ch13", 13, base, a, b);
  endtask

  task automatic t_no_high();
    int base;
    to_tick();
    base = nrec;
    lo[5] = 1'b1;
    ticks(4); lo[5] = 1'b0;
    ticks(6);
    chk(nrec == base, "R5 unconfirmed window writes nothing", nrec - base, 0);
  endtask

  task automatic t_high_only();
    int base;
    to_tick();
    base = nrec;
    hi[9] = 1'b1;
    ticks(3); hi[9] = 1'b0;
    // Window that closes exactly as the high comparator arrives.
    lo[9] = 1'b1;
    ticks(2); lo[9] = 1'b0; hi[9] = 1'b1;
    ticks(2); hi[9] = 1'b0;
    ticks(6);
    chk(nrec == base, "R6 high outside window writes nothing", nrec - base, 0);
  endtask

  task automatic t_two_ch();
    int base, a;
    to_tick();
    base = nrec;
    a = stamp();
    lo[1] = 1'b1; hi[1] = 1'b1;
    ticks(1); lo[14] = 1'b1;
    ticks(1); hi[14] = 1'b1; hi[1] = 1'b0;
    ticks(1); lo[1] = 1'b0;
    ticks(1); lo[14] = 1'b0; hi[14] = 1'b0;
    ticks(8);
    expect_pair("R7 ch1 of two", 1, base, a, a + 3);
    expect_pair("R7 ch14 of two", 14, base, a + 1, a + 4);
    chk(nrec - base == 4, "R7 total records two channels", nrec - base, 4);
    chk(!overflow, "R8 no overflow under light load", int'(overflow), 0);
  endtask

  task automatic t_wrap();
    int base, a, b;
    while (stamp() != TMOD - 2) to_tick();
    base = nrec;
    a = stamp(); lo[6] = 1'b1; hi[6] = 1'b1;
    ticks(3); b = stamp(); lo[6] = 1'b0; hi[6] = 1'b0;
    ticks(6);
    chk(b == 1, "R1 stamp after wrap", b, 1);
    expect_pair("R1 pulse across wrap ch6", 6, base, a, b);
  endtask

  task automatic t_overflow();
    int base, n, good;
    to_tick();
    base = nrec;
    for (int i = 0; i < 12; i++) begin
      lo[0] = 1'b1; hi[0] = 1'b1;
      ticks(1);
      lo[0] = 1'b0; hi[0] = 1'b0;
      ticks(1);
    end
    ticks(20);
    chk(overflow, "R8 overflow raised", int'(overflow), 1);
    n = count_ch(0, base);
    chk(n < 24 && n > 0, "R8 some pulses dropped", n, 12);
    chk(n % 2 == 0, "R8 records come in whole pairs", n % 2, 0);
    good = 1;
    for (int j = 0; j + 1 < n; j += 2) begin
      int a, b;
      a = nth_ch(0, j, base);
      b = nth_ch(0, j + 1, base);
      if (rtr[a] != 0 || rtr[b] != 1 || ((rtm[b] - rtm[a] + TMOD) % TMOD) != 1) good = 0;
    end
    chk(good == 1, "R4 R8 each kept lead followed by its trail", good, 1);
    // Flag stays set and normal recording carries on.
    base = nrec;
    to_tick();
    lo[3] = 1'b1; hi[3] = 1'b1;
    ticks(2); lo[3] = 1'b0; hi[3] = 1'b0;
    ticks(6);
    chk(count_ch(3, base) == 2, "R8 recording after overflow", count_ch(3, base), 2);
    chk(overflow, "R8 overflow sticky", int'(overflow), 1);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_accept();
    t_same_tick();
    t_no_high();
    t_high_only();
    t_two_ch();
    t_overflow();
    t_wrap();
    chk(slot_seen > 0 && slot_bad == 0, "R7 slot ownership", slot_bad, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule